// File: doc/BRIEF.md
# Microwire EEPROM Station-Address Loader

This block fetches a station (MAC) address from a 4-wire Microwire serial EEPROM. It starts on its own when reset is released. It reads a fixed number of 16-bit words from consecutive addresses, one READ transaction per word, and stores each word as two bytes, upper byte first, in an internal byte image.

Once the last word is stored, the block XORs a configured span of image bytes together and compares the result with a stored check byte. When the two agree, six consecutive image bytes are published as a 48-bit address with a valid flag. When they differ, an error flag is raised and the address output stays zero.

Every SK half-period lasts a parameterised number of system clocks, so the pins meet the device's minimum high and low times. A one-cycle start pulse abandons any read in progress and runs the whole sequence again.

Top module: `microwire_addr_loader`

## Requirements
- R1: After reset is released, busy is 1; done, addr_valid, checksum_error and mac are 0; eeprom_cs and eeprom_sk are low. Reading begins without a start pulse.
- R2: Each SK high phase and each SK low phase lasts exactly CLK_DIV clock cycles. SK is never high while CS is low.
- R3: Each transaction opens with CS high and one SK pulse with DI = 0. It then clocks a start bit of 1 and the READ opcode bits 1 then 0. Each DI bit is set while SK is low and held while SK is high.
- R4: The WORD_ADDR_BITS-bit word address follows the opcode, most significant bit first. In a run, transaction k uses address k, for k = 0 to NUM_WORDS-1 in order.
- R5: After the address, SK stays low for one phase. Then 16 data bits are read most significant bit first, each as an SK high phase followed by an SK low phase, with DO sampled at the end of the low phase. Word k bits 15:8 become image byte 2k and bits 7:0 become image byte 2k+1.
- R6: CS goes low after every word, giving exactly 26 SK pulses per completed transaction. A run makes NUM_WORDS transactions.
- R7: The checksum is the XOR of image bytes CSUM_FIRST up to CSUM_BYTE-1, compared with image byte CSUM_BYTE. Bytes outside that span do not affect the result.
- R8: On a match, done = 1, addr_valid = 1, checksum_error = 0, and mac holds image bytes MAC_OFS to MAC_OFS+5, with byte MAC_OFS in mac[47:40].
- R9: On a mismatch, done = 1, addr_valid = 0, checksum_error = 1 and mac = 0.
- R10: busy falls on the same clock edge on which done rises. The result then holds, unchanged, until the next start.
- R11: A start pulse in any cycle clears done, addr_valid, checksum_error and mac on the next edge, sets busy, and restarts reading at word address 0.
- R12: If start arrives in the cycle in which the checksum is judged, the restart wins: no result is published and a fresh run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse: abandon the current run and restart |
| eeprom_cs | output | 1 | EEPROM chip select, active high |
| eeprom_sk | output | 1 | EEPROM serial clock |
| eeprom_di | output | 1 | Serial data to the EEPROM |
| eeprom_do | input | 1 | Serial data from the EEPROM |
| busy | output | 1 | A read run or check is in progress |
| done | output | 1 | A result is available |
| addr_valid | output | 1 | The checksum matched and mac is valid |
| checksum_error | output | 1 | The checksum did not match |
| mac | output | 48 | Station address, first image byte in the top bits |

## Verification
A restart request and the checksum judgement can both fall in the one clock cycle that follows the last data sample. The bench finds that cycle at the pins: after the EEPROM model has shifted out the final data bit of the run, the first cycle that shows CS low is the judgement cycle. The bench raises start in exactly that cycle. It then expects done to stay low and busy to stay high on the next edge, and afterwards a complete fresh run with a correct address.

// File: rtl/mwl_pkg.sv
// Package: shared constants and the sequencer state type for the
// Microwire address loader. Assumes 16-bit EEPROM words.
package mwl_pkg;
    localparam int WORD_BITS = 16;
    localparam int MAC_BYTES = 6;
    // start bit followed by the two READ opcode bits
    localparam logic [2:0] MW_READ_HDR = 3'b110;

    typedef enum logic [2:0] {
        ST_GAP,     // CS low for one phase between transactions
        ST_OUT_LO,  // SK low, DI carries the current outgoing bit
        ST_OUT_HI,  // SK high, device captures DI
        ST_TURN,    // SK low for one phase, skips the dummy zero
        ST_DAT_HI,  // SK high, device shifts out a data bit
        ST_DAT_LO,  // SK low, DO sampled at the end of the phase
        ST_CHECK,   // one cycle: checksum judged
        ST_DONE     // result held until start
    } mwl_state_t;
endpackage

// File: rtl/mwl_phase_timer.sv
// Module: phase timer. Produces a one-cycle tick at the end of every
// SK phase of DIV clocks. Assumes DIV >= 1; restart or !run clears it.
module mwl_phase_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(DIV - 1));

    // Count clocks within the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_PHASE_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt) < DIV)) else $error("phase counter out of range"); // R2
endmodule

// File: rtl/mwl_read_seq.sv
// Module: Microwire READ sequencer. Drives CS/SK/DI for NUM_WORDS
// sequential word reads, samples DO, hands each word out with its
// index, then requests one checksum judgement. Assumes 16-bit words and
// that the device shifts data out on the rising SK.
module mwl_read_seq
    import mwl_pkg::*;
#(
    parameter int NUM_WORDS      = 16,
    parameter int WORD_ADDR_BITS = 6,
    parameter int IW             = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 tick,
    input  logic                 mw_do,
    output logic                 mw_cs,
    output logic                 mw_sk,
    output logic                 mw_di,
    output logic                 phase_run,
    output logic                 word_we,
    output logic [IW-1:0]        word_idx,
    output logic [WORD_BITS-1:0] word_data,
    output logic                 check_en,
    output logic                 busy
);
    localparam int OUTW = 1 + 3 + WORD_ADDR_BITS;
    localparam int MAXB = (OUTW > WORD_BITS) ? OUTW : WORD_BITS;
    localparam int BCW  = $clog2(MAXB);

    mwl_state_t           state;
    logic [BCW-1:0]       bit_cnt;
    logic [WORD_BITS-1:0] din;
    logic [OUTW-1:0]      out_vec;
    logic                 last_out, last_dat, last_word;

    // Preamble zero, start bit, opcode and address, sent MSB first.
    assign out_vec   = {1'b0, MW_READ_HDR, WORD_ADDR_BITS'(word_idx)};
    assign last_out  = (bit_cnt == BCW'(OUTW - 1));
    assign last_dat  = (bit_cnt == BCW'(WORD_BITS - 1));
    assign last_word = (word_idx == IW'(NUM_WORDS - 1));

    // Pin decode from the current phase.
    always_comb begin
        mw_cs = (state == ST_OUT_LO) || (state == ST_OUT_HI) || (state == ST_TURN) ||
                (state == ST_DAT_HI) || (state == ST_DAT_LO);
        mw_sk = (state == ST_OUT_HI) || (state == ST_DAT_HI);
        mw_di = 1'b0;
        if ((state == ST_OUT_LO) || (state == ST_OUT_HI)) begin
            mw_di = out_vec[(OUTW - 1) - int'(bit_cnt)];
        end
    end

    assign phase_run = (state != ST_CHECK) && (state != ST_DONE);
    assign busy      = (state != ST_DONE);
    assign word_we   = tick && (state == ST_DAT_LO) && last_dat && !start;
    assign word_data = {din[WORD_BITS-2:0], mw_do};
    assign check_en  = (state == ST_CHECK) && !start;

    // Phase sequencing, bit and word counting, DO capture.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            state    <= ST_GAP;
            bit_cnt  <= '0;
            word_idx <= '0;
            din      <= '0;
        end else begin
            case (state)
                ST_GAP: if (tick) begin
                    state   <= ST_OUT_LO;
                    bit_cnt <= '0;
                end
                ST_OUT_LO: if (tick) state <= ST_OUT_HI;
                ST_OUT_HI: if (tick) begin
                    if (last_out) begin
                        state <= ST_TURN;
                    end else begin
                        state   <= ST_OUT_LO;
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_TURN: if (tick) begin
                    state   <= ST_DAT_HI;
                    bit_cnt <= '0;
                end
                ST_DAT_HI: if (tick) state <= ST_DAT_LO;
                ST_DAT_LO: if (tick) begin
                    din <= word_data;
                    if (last_dat) begin
                        if (last_word) begin
                            state <= ST_CHECK;
                        end else begin
                            state    <= ST_GAP;
                            word_idx <= word_idx + 1'b1;
                        end
                    end else begin
                        state   <= ST_DAT_HI;
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_CHECK: state <= ST_DONE;
                default:  state <= ST_DONE;
            endcase
        end
    end

    AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        mw_sk |-> mw_cs) else $error("SK high with CS low"); // R2
    AST_DI_HELD_ON_SK: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_sk && $past(mw_sk) && !$past(start)) |-> $stable(mw_di)) else $error("DI moved while SK high"); // R3
    AST_CS_DROPS_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        word_we |=> !mw_cs) else $error("CS still high after a word"); // R6
endmodule

// File: rtl/mwl_image_check.sv
// Module: byte image, checksum judgement and address extraction.
// Stores each word upper byte first, XORs the configured span when
// check_en pulses and registers the result until clear. Assumes the
// parameters keep every index inside the image.
module mwl_image_check
    import mwl_pkg::*;
#(
    parameter int NUM_WORDS  = 16,
    parameter int CSUM_FIRST = 2,
    parameter int CSUM_BYTE  = 30,
    parameter int MAC_OFS    = 8,
    parameter int IW         = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 word_we,
    input  logic [IW-1:0]        word_idx,
    input  logic [WORD_BITS-1:0] word_data,
    input  logic                 check_en,
    output logic                 done,
    output logic                 addr_valid,
    output logic                 checksum_error,
    output logic [8*MAC_BYTES-1:0] mac
);
    localparam int IMG_BYTES = 2 * NUM_WORDS;

    logic [7:0]             img [IMG_BYTES];
    logic [7:0]             csum;
    logic                   match;
    logic [8*MAC_BYTES-1:0] mac_c;

    // Store each arriving word as two bytes, upper byte first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < IMG_BYTES; i++) img[i] <= '0;
        end else if (word_we) begin
            for (int k = 0; k < NUM_WORDS; k++) begin
                if (word_idx == IW'(k)) begin
                    img[2*k]   <= word_data[15:8];
                    img[2*k+1] <= word_data[7:0];
                end
            end
        end
    end

    // XOR of the protected span and comparison with the stored byte.
    always_comb begin
        csum = '0;
        for (int i = CSUM_FIRST; i < CSUM_BYTE; i++) csum = csum ^ img[i];
        match = (csum == img[CSUM_BYTE]);
    end

    // Assemble the address, first image byte in the top bits.
    always_comb begin
        for (int j = 0; j < MAC_BYTES; j++) begin
            mac_c[8*(MAC_BYTES-1-j) +: 8] = img[MAC_OFS + j];
        end
    end

    // Register the judgement; clear wipes it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            done           <= 1'b0;
            addr_valid     <= 1'b0;
            checksum_error <= 1'b0;
            mac            <= '0;
        end else if (check_en) begin
            done           <= 1'b1;
            addr_valid     <= match;
            checksum_error <= !match;
            mac            <= match ? mac_c : '0;
        end
    end

    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (addr_valid != checksum_error)) else $error("result flags inconsistent"); // R8
    AST_MAC_ZERO_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        checksum_error |-> (mac == '0)) else $error("address leaked on failure"); // R9
    AST_FLAGS_NEED_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid || checksum_error) |-> done) else $error("flag without done"); // R10
    AST_CLEAR_WIPES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !done) else $error("done survived clear"); // R11
endmodule

// File: rtl/microwire_addr_loader.sv
// Module: top of the Microwire station-address loader. Ties the phase
// timer, the READ sequencer and the image/check stage together. Assumes
// a one-cycle start pulse and a 4-wire EEPROM in 16-bit word mode.
module microwire_addr_loader
    import mwl_pkg::*;
#(
    parameter int CLK_DIV        = 4,
    parameter int NUM_WORDS      = 16,
    parameter int WORD_ADDR_BITS = 6,
    parameter int CSUM_FIRST     = 2,
    parameter int CSUM_BYTE      = 30,
    parameter int MAC_OFS        = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        eeprom_cs,
    output logic        eeprom_sk,
    output logic        eeprom_di,
    input  logic        eeprom_do,
    output logic        busy,
    output logic        done,
    output logic        addr_valid,
    output logic        checksum_error,
    output logic [47:0] mac
);
    localparam int IW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    logic                 tick, phase_run, word_we, check_en;
    logic [IW-1:0]        word_idx;
    logic [WORD_BITS-1:0] word_data;

    mwl_phase_timer #(.DIV(CLK_DIV)) timer_i (
        .clk(clk), .rst_n(rst_n), .restart(start), .run(phase_run), .tick(tick)
    );

    mwl_read_seq #(
        .NUM_WORDS(NUM_WORDS), .WORD_ADDR_BITS(WORD_ADDR_BITS), .IW(IW)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .mw_do(eeprom_do),
        .mw_cs(eeprom_cs), .mw_sk(eeprom_sk), .mw_di(eeprom_di),
        .phase_run(phase_run), .word_we(word_we), .word_idx(word_idx),
        .word_data(word_data), .check_en(check_en), .busy(busy)
    );

    mwl_image_check #(
        .NUM_WORDS(NUM_WORDS), .CSUM_FIRST(CSUM_FIRST), .CSUM_BYTE(CSUM_BYTE),
        .MAC_OFS(MAC_OFS), .IW(IW)
    ) img_i (
        .clk(clk), .rst_n(rst_n), .clear(start), .word_we(word_we),
        .word_idx(word_idx), .word_data(word_data), .check_en(check_en),
        .done(done), .addr_valid(addr_valid), .checksum_error(checksum_error),
        .mac(mac)
    );

    AST_BUSY_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)) else $error("busy and done together"); // R10
    AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done) else $error("busy fell without done"); // R10
endmodule

// File: tb/microwire_addr_loader_tb_top.sv
// Bench: directed scenarios against a behavioural Microwire EEPROM model.
module microwire_addr_loader_tb_top;
    localparam int CLK_DIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic eeprom_cs, eeprom_sk, eeprom_di, eeprom_do;
    logic busy, done, addr_valid, checksum_error;
    logic [47:0] mac;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    microwire_addr_loader #(.CLK_DIV(CLK_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .eeprom_cs(eeprom_cs), .eeprom_sk(eeprom_sk), .eeprom_di(eeprom_di),
        .eeprom_do(eeprom_do), .busy(busy), .done(done), .addr_valid(addr_valid),
        .checksum_error(checksum_error), .mac(mac)
    );

    // ---------------- EEPROM model ----------------
    logic [15:0] rom [64];
    logic [7:0]  img [32];
    logic        m_on = 1'b0, m_first = 1'b1, m_do = 1'b0;
    int          m_cnt = 0, m_pulses = 0;
    logic [7:0]  m_cmd = '0;
    logic [15:0] m_sh = '0;
    int          served = 0, bad_op = 0, pre_bad = 0, pulse_bad = 0;
    int          addr_log [256];
    int          log_n = 0;

    assign eeprom_do = m_do;

    always @(posedge eeprom_sk or negedge eeprom_cs) begin
        if (!eeprom_cs) begin
            if (m_pulses != 0 && m_pulses != 26) pulse_bad++;
            m_on = 1'b0; m_do = 1'b0; m_first = 1'b1; m_pulses = 0;
        end else begin
            m_pulses++;
            if (m_first) begin
                if (eeprom_di) pre_bad++;
                m_first = 1'b0;
            end else if (!m_on) begin
                if (eeprom_di) begin m_on = 1'b1; m_cnt = 0; end
            end else if (m_cnt < 8) begin
                m_cmd = {m_cmd[6:0], eeprom_di};
                m_cnt++;
                if (m_cnt == 8) begin
                    if (m_cmd[7:6] != 2'b10) bad_op++;
                    if (log_n < 256) addr_log[log_n] = int'(m_cmd[5:0]);
                    log_n++;
                    m_sh = rom[m_cmd[5:0]];
                    m_do = 1'b0;
                end
            end else if (m_cnt < 24) begin
                m_do = m_sh[15];
                m_sh = {m_sh[14:0], 1'b0};
                m_cnt++;
                if (m_cnt == 24) served++;
            end
        end
    end

    // SK high-phase width monitor
    int sk_len = 0, width_bad = 0;
    always @(negedge clk) begin
        if (eeprom_sk) sk_len++;
        else begin
            if (sk_len != 0 && sk_len != CLK_DIV) width_bad++;
            sk_len = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_mac();
        logic [47:0] m;
        for (int j = 0; j < 6; j++) m[8*(5-j) +: 8] = img[8 + j];
        return m;
    endfunction

    task automatic build_image(input int seed, input int corrupt_at);
        logic [7:0] x;
        for (int i = 0; i < 32; i++) img[i] = 8'((i * 37 + seed * 11 + 5) ^ (i << 3));
        x = '0;
        for (int i = 2; i < 30; i++) x = x ^ img[i];
        img[30] = x;
        if (corrupt_at >= 0) img[corrupt_at] = img[corrupt_at] ^ 8'h5A;
        for (int k = 0; k < 64; k++) rom[k] = 16'hDEAD;
        for (int k = 0; k < 16; k++) rom[k] = {img[2*k], img[2*k+1]};
    endtask

    task automatic clear_mon();
        served = 0; bad_op = 0; pre_bad = 0; pulse_bad = 0; log_n = 0; width_bad = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        clear_mon();
        rst_n = 1'b1;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        chk(done == 1'b1, req, 64'(done), 64'd1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        build_image(1, -1);
        do_reset();
        @(negedge clk);
        chk(busy == 1'b1, "R1 busy", 64'(busy), 1);
        chk({done, addr_valid, checksum_error} == 3'b000, "R1 flags", 64'({done, addr_valid, checksum_error}), 0);
        chk(mac == '0, "R1 mac", 64'(mac), 0);
        chk({eeprom_cs, eeprom_sk} == 2'b00, "R1 pins", 64'({eeprom_cs, eeprom_sk}), 0);
    endtask

    task automatic t_good();
        bit order_ok = 1'b1;
        wait_done("R8 done");
        chk(addr_valid && !checksum_error, "R8 valid", 64'({addr_valid, checksum_error}), 64'b10);
        chk(mac == exp_mac(), "R5 R8 mac", 64'(mac), 64'(exp_mac()));
        chk(busy == 1'b0, "R10 busy low", 64'(busy), 0);
        for (int i = 0; i < 16; i++) if (addr_log[i] != i) order_ok = 1'b0;
        chk(order_ok && log_n == 16, "R4 address order", 64'(log_n), 16);
        chk(served == 16, "R6 words", 64'(served), 16);
        chk(bad_op == 0 && pre_bad == 0, "R3 command", 64'(bad_op + pre_bad), 0);
        chk(pulse_bad == 0, "R5 R6 pulses per word", 64'(pulse_bad), 0);
        chk(width_bad == 0, "R2 SK width", 64'(width_bad), 0);
    endtask

    task automatic t_hold();
        logic [47:0] m0 = mac;
        repeat (400) @(negedge clk);
        chk(done && addr_valid && mac == m0 && !busy, "R10 hold", 64'(mac), 64'(m0));
    endtask

    task automatic t_bad_csum();
        build_image(2, 20);
        do_reset();
        wait_done("R9 done");
        chk(checksum_error && !addr_valid, "R9 flags", 64'({addr_valid, checksum_error}), 64'b01);
        chk(mac == '0, "R9 mac zero", 64'(mac), 0);
    endtask

    task automatic t_outside();
        build_image(3, -1);
        img[0] = ~img[0]; img[1] = img[1] ^ 8'h33; img[31] = ~img[31];
        for (int k = 0; k < 16; k++) rom[k] = {img[2*k], img[2*k+1]};
        do_reset();
        wait_done("R7 done");
        chk(addr_valid && !checksum_error, "R7 outside span ignored", 64'({addr_valid, checksum_error}), 64'b10);
        chk(mac == exp_mac(), "R7 mac", 64'(mac), 64'(exp_mac()));
    endtask

    task automatic t_start_clears();
        build_image(4, -1);
        pulse_start();
        chk(!done && !addr_valid && mac == '0 && busy, "R11 cleared", 64'({done, addr_valid, busy}), 64'b001);
        clear_mon();
        wait_done("R11 rerun");
        chk(addr_valid && mac == exp_mac(), "R11 new result", 64'(mac), 64'(exp_mac()));
        chk(addr_log[0] == 0, "R11 restart at 0", 64'(addr_log[0]), 0);
    endtask

    task automatic t_mid_restart();
        int at;
        int t = 0;
        build_image(5, -1);
        pulse_start();
        clear_mon();
        while (served < 5 && t < 20000) begin @(negedge clk); t++; end
        repeat (30) @(negedge clk);
        at = log_n;
        pulse_start();
        wait_done("R11 mid done");
        chk(addr_log[at] == 0, "R11 mid restart address", 64'(addr_log[at]), 0);
        chk(addr_valid && mac == exp_mac(), "R11 mid result", 64'(mac), 64'(exp_mac()));
    endtask

    task automatic t_collide();
        int t = 0;
        build_image(6, -1);
        pulse_start();
        clear_mon();
        while (served < 16 && t < 20000) begin @(negedge clk); t++; end
        while (eeprom_cs && t < 20000) begin @(negedge clk); t++; end
        pulse_start();
        chk(!done && busy, "R12 restart wins", 64'({done, busy}), 64'b01);
        repeat (CLK_DIV * 60) @(negedge clk);
        chk(!done && log_n >= 17, "R12 new run", 64'(log_n), 17);
        wait_done("R12 later done");
        chk(addr_valid && mac == exp_mac(), "R12 result", 64'(mac), 64'(exp_mac()));
    endtask

    // ---------------- main ----------------
    initial begin
        t_reset();
        t_good();
        t_hold();
        t_bad_csum();
        t_outside();
        t_start_clears();
        t_mid_restart();
        t_collide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule